// File: doc/BRIEF.md
# Partitioned LFSR Test Pattern Generator

This block produces stimulus for a circuit under test from several short, independent division-type LFSR segments instead of one long register. Each segment has its own feedback polynomial and its own fixed seed. The stage outputs of all segments are joined into one output index space. A fixed routing table then connects each circuit input to one of those outputs, either directly or through an inverter. One output may feed several inputs, and an output may be left unconnected. The total register length can therefore be smaller or larger than the pattern width.

A pulse on the start input clears every segment and loads all seeds serially and in parallel. This takes as many cycles as the longest segment has stages. The valid strobe then rises and the seeded pattern is on the output. After that, each cycle with the generate enable high advances every segment by one step. Polynomials, seeds and routing are elaboration parameters. An elaboration check rejects any circuit input that has no driver or more than one driver.

Top module: `lfsr_part_gen`

## Requirements
- R1: After reset the valid strobe is low and every segment holds zero. The pattern is therefore the routed all-zero state, which is 10'h005 in the default configuration (bits I3 and I1 come from inverted outputs).
- R2: After a cycle with start high, valid stays low for exactly as many cycles as the longest segment has stages (4 by default), then rises. Valid remains high until the next start.
- R3: When seeding completes, every segment holds its seed (seed strings written with the highest stage first). In the default configuration the pattern is 10'h035.
- R4: In each cycle with valid and the generate enable both high, every segment takes one division step. Stages are numbered 1 to L, and the top stage L is the feedback bit. Stage 1 takes the feedback bit. Stage i, for i from 2 to L, takes stage i-1 XOR (feedback AND the coefficient of x^(i-1)). A nonzero state never steps to zero.
- R5: While valid is high and the generate enable is low, the pattern holds its value.
- R6: The generate enable has no effect while idle after reset or while seeding. The idle pattern stays at its reset value, and seeding still ends in the seed state.
- R7: Outputs are numbered from the total stage count down to 1. The highest-numbered segment takes the highest numbers, and inside a segment stage j is the lowest number plus j-1. In the default map (segments x^4+x^3+1, x^3+x^2+1, x^3+x+1), the pattern from I10 down to I1 is {O10, O9, O1, O9, O8, O7, O6, ~O5, O3, ~O6}. O4 and O2 are unused.
- R8: A start while running drops valid on the next cycle and seeds again, giving the same seeded pattern as the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clear all segments and begin seeding |
| gen_en_i | input | 1 | Advance all segments by one step while valid |
| pattern_o | output | PAT_W | Routed pattern applied to the circuit under test |
| valid_o | output | 1 | High once seeding has completed |

## Verification
The bench steps the generator for 105 cycles, the least common multiple of the three segment periods, and expects the seeded pattern again. A wrong tap position or a misplaced feedback bit breaks that period. The bench holds the enable high during idle and during seeding, so a design that let it leak would start from a shifted state. A restart issued while running must reproduce the same seeded pattern, which catches a seed counter that is not cleared. Comparing every stepped pattern against an independent model of the routing exposes a swapped broadcast target, a dropped inversion or a segment placed at the wrong offset.

// File: rtl/plg_pkg.sv
package plg_pkg;
  localparam int unsigned LEN_W   = 8;
  localparam int unsigned MAX_SEG = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEED = 2'd1,
    PH_RUN  = 2'd2
  } plg_phase_e;

  // sum of the first n segment lengths (segment 1 in the lowest field)
  function automatic int unsigned sum_len(logic [MAX_SEG*LEN_W-1:0] lens, int unsigned n);
    int unsigned acc = 0;
    for (int unsigned s = 0; s < MAX_SEG; s++)
      if (s < n) acc += int'(lens[s*LEN_W +: LEN_W]);
    return acc;
  endfunction

  function automatic int unsigned max_len(logic [MAX_SEG*LEN_W-1:0] lens, int unsigned n);
    int unsigned m = 0;
    for (int unsigned s = 0; s < MAX_SEG; s++)
      if (s < n && int'(lens[s*LEN_W +: LEN_W]) > m) m = int'(lens[s*LEN_W +: LEN_W]);
    return m;
  endfunction
endpackage

// File: rtl/plg_ctrl.sv
module plg_ctrl
  import plg_pkg::*;
#(
  parameter  int unsigned SEED_CYC = 4,
  localparam int unsigned CNT_W    = $clog2(SEED_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             gen_en_i,
  output logic             clr_o,
  output logic             load_o,
  output logic             step_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEED_CYC - 1);

  plg_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_SEED;
      cnt_q   <= '0;
    end else if (phase_q == PH_SEED) begin
      if (cnt_q == LAST) begin
        phase_q <= PH_RUN;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clr_o   = start_i;
  assign load_o  = (phase_q == PH_SEED);
  assign valid_o = (phase_q == PH_RUN);
  assign step_o  = valid_o && gen_en_i && !start_i;
  assign cnt_o   = cnt_q;

  AST_SEED_TO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && cnt_o == LAST && !start_i) |=> valid_o); // R2
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> valid_o); // R2
  AST_START_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (load_o && cnt_o == '0 && !valid_o)); // R8
  AST_RISE_AFTER_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(load_o)); // R2
endmodule

// File: rtl/plg_segment.sv
module plg_segment #(
  parameter int unsigned     LEN      = 4,
  parameter int unsigned     FLD_W    = 8,
  parameter int unsigned     SEED_CYC = 4,
  parameter int unsigned     CNT_W    = 3,
  parameter logic [FLD_W-1:0] POLY    = '0,
  parameter logic [FLD_W-1:0] SEED    = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LEN-1:0]   state_o
);
  logic [LEN-1:0] state_q, state_d;
  logic           seed_bit, fb;

  // shorter segments receive zeros first, seed bits (top stage first) last
  always_comb begin
    seed_bit = 1'b0;
    for (int b = 0; b < int'(LEN); b++)
      if (int'(cnt_i) == int'(SEED_CYC) - 1 - b) seed_bit = SEED[b];
  end

  assign fb = state_q[LEN-1];

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d[0] = seed_bit;
      for (int i = 1; i < int'(LEN); i++) state_d[i] = state_q[i-1];
    end else if (step_i) begin
      state_d[0] = fb;
      for (int i = 1; i < int'(LEN); i++) state_d[i] = state_q[i-1] ^ (fb & POLY[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= '0;
    else if (clr_i)   state_q <= '0;
    else              state_q <= state_d;
  end

  assign state_o = state_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> state_q == '0); // R2
  AST_SEED_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && int'(cnt_i) == int'(SEED_CYC) - 1) |=> state_q == SEED[LEN-1:0]); // R3
  AST_HOLD_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !step_i) |=> $stable(state_q)); // R5
  AST_NO_LOCKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && !load_i && state_q != '0) |=> state_q != '0); // R4
endmodule

// File: rtl/plg_router.sv
module plg_router #(
  parameter int unsigned             TOTAL   = 10,
  parameter int unsigned             PAT_W   = 10,
  parameter logic [TOTAL*PAT_W-1:0]  DIR_MAP = '0,
  parameter logic [TOTAL*PAT_W-1:0]  INV_MAP = '0
) (
  input  logic [TOTAL-1:0] src_i,
  output logic [PAT_W-1:0] pat_o
);
  function automatic int unsigned drivers(int unsigned j);
    int unsigned c = 0;
    for (int unsigned n = 0; n < TOTAL; n++)
      c += int'(DIR_MAP[n*PAT_W + j]) + int'(INV_MAP[n*PAT_W + j]);
    return c;
  endfunction

  for (genvar j = 0; j < int'(PAT_W); j++) begin : g_in
    if (drivers(j) != 1) begin : g_bad_map
      $error("route map: input %0d has %0d drivers", j + 1, drivers(j));
    end
    always_comb begin
      pat_o[j] = 1'b0;
      for (int n = 0; n < int'(TOTAL); n++)
        pat_o[j] = pat_o[j] | (src_i[n] & DIR_MAP[n*PAT_W + j])
                            | (~src_i[n] & INV_MAP[n*PAT_W + j]);
    end
  end
endmodule

// File: rtl/lfsr_part_gen.sv
module lfsr_part_gen
  import plg_pkg::*;
#(
  parameter  int unsigned NUM_SEG = 3,
  parameter  int unsigned FLD_W   = 8,
  // segment s+1 in field s; lengths, polynomial coefficients (bit j = x^j), seeds
  parameter  logic [NUM_SEG*LEN_W-1:0] SEG_LEN  = {8'd4, 8'd3, 8'd3},
  parameter  logic [NUM_SEG*FLD_W-1:0] SEG_POLY = {8'h19, 8'h0D, 8'h0B},
  parameter  logic [NUM_SEG*FLD_W-1:0] SEG_SEED = {8'h03, 8'h01, 8'h02},
  parameter  int unsigned PAT_W   = 10,
  localparam int unsigned TOTAL   = sum_len((MAX_SEG*LEN_W)'(SEG_LEN), NUM_SEG),
  localparam int unsigned SEED_CYC = max_len((MAX_SEG*LEN_W)'(SEG_LEN), NUM_SEG),
  // output n (1-based) owns bits [(n-1)*PAT_W +: PAT_W]; bit j-1 targets input j
  parameter  logic [TOTAL*PAT_W-1:0] ROUTE_DIR = {
    10'b10_0000_0000, 10'b01_0100_0000, 10'b00_0010_0000, 10'b00_0001_0000,
    10'b00_0000_1000, 10'b00_0000_0000, 10'b00_0000_0000, 10'b00_0000_0010,
    10'b00_0000_0000, 10'b00_1000_0000},
  parameter  logic [TOTAL*PAT_W-1:0] ROUTE_INV = {
    10'b00_0000_0000, 10'b00_0000_0000, 10'b00_0000_0000, 10'b00_0000_0000,
    10'b00_0000_0001, 10'b00_0000_0100, 10'b00_0000_0000, 10'b00_0000_0000,
    10'b00_0000_0000, 10'b00_0000_0000}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             gen_en_i,
  output logic [PAT_W-1:0] pattern_o,
  output logic             valid_o
);
  localparam int unsigned CNT_W = $clog2(SEED_CYC + 1);

  logic             clr, load, step;
  logic [CNT_W-1:0] cnt;
  logic [TOTAL-1:0] out_vec;

  plg_ctrl #(.SEED_CYC(SEED_CYC)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .gen_en_i (gen_en_i),
    .clr_o    (clr),
    .load_o   (load),
    .step_o   (step),
    .valid_o  (valid_o),
    .cnt_o    (cnt)
  );

  for (genvar s = 0; s < int'(NUM_SEG); s++) begin : g_seg
    localparam int unsigned L   = int'(SEG_LEN[s*LEN_W +: LEN_W]);
    localparam int unsigned OFF = sum_len((MAX_SEG*LEN_W)'(SEG_LEN), s);
    logic [L-1:0] st;

    if (L < 2 || L > FLD_W) begin : g_bad_len
      $error("segment %0d length %0d out of range", s + 1, L);
    end

    plg_segment #(
      .LEN      (L),
      .FLD_W    (FLD_W),
      .SEED_CYC (SEED_CYC),
      .CNT_W    (CNT_W),
      .POLY     (SEG_POLY[s*FLD_W +: FLD_W]),
      .SEED     (SEG_SEED[s*FLD_W +: FLD_W])
    ) u_seg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .load_i  (load),
      .step_i  (step),
      .cnt_i   (cnt),
      .state_o (st)
    );

    assign out_vec[OFF +: L] = st;
  end

  plg_router #(
    .TOTAL   (TOTAL),
    .PAT_W   (PAT_W),
    .DIR_MAP (ROUTE_DIR),
    .INV_MAP (ROUTE_INV)
  ) u_router (
    .src_i (out_vec),
    .pat_o (pattern_o)
  );

  AST_IDLE_PATTERN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !load && !start_i) |=> $stable(pattern_o)); // R6
  AST_PAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !gen_en_i && !start_i) |=> $stable(pattern_o)); // R5
endmodule

// File: tb/lfsr_part_gen_test.sv
`timescale 1ns/1ps
module lfsr_part_gen_test;
  localparam int PER = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       gen_en = 1'b0;
  logic [9:0] pattern;
  logic       valid;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [9:0] exp_q[$];

  // bench model: segment 3 (len 4), 2 (len 3), 1 (len 3)
  logic [7:0] m_st [3];
  int         m_len [3]  = '{3, 3, 4};
  logic [7:0] m_poly [3] = '{8'h0B, 8'h0D, 8'h19};
  logic [7:0] m_seed [3] = '{8'h02, 8'h01, 8'h03};

  always #(PER / 2.0) clk = ~clk;

  lfsr_part_gen uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .gen_en_i  (gen_en),
    .pattern_o (pattern),
    .valid_o   (valid)
  );

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] seg_step(logic [7:0] s, int len, logic [7:0] poly);
    logic [7:0] n = '0;
    logic fb = s[len-1];
    n[0] = fb;
    for (int i = 1; i < len; i++) n[i] = s[i-1] ^ (fb & poly[i]);
    return n;
  endfunction

  // R7: O10..O1 = seg3[3:0], seg2[2:0], seg1[2:0]
  function automatic logic [9:0] model_pat();
    logic [9:0] o;
    o = {m_st[2][3:0], m_st[1][2:0], m_st[0][2:0]};
    return {o[9], o[8], o[0], o[8], o[7], o[6], o[5], ~o[4], o[2], ~o[5]};
  endfunction

  task automatic model_seed();
    for (int s = 0; s < 3; s++) m_st[s] = m_seed[s];
  endtask

  task automatic model_step();
    for (int s = 0; s < 3; s++) m_st[s] = seg_step(m_st[s], m_len[s], m_poly[s]);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [9:0] e;
      e = exp_q.pop_front();
      check(valid === 1'b1 && pattern === e, "R4/R5/R7 stepped pattern",
            {5'd0, valid, pattern}, {6'd1, e});
    end
  end

  task automatic drive_steps(int n, logic [15:0] en_mask, bit cyc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      gen_en = cyc ? en_mask[i % 16] : en_mask[0];
      if (gen_en) model_step();
      exp_q.push_back(model_pat());
    end
    @(negedge clk);
    gen_en = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic do_start(string req);
    @(negedge clk);
    start = 1'b1;
    gen_en = 1'b1;             // R6: enable must not disturb seeding
    @(negedge clk);
    start = 1'b0;
    check(valid === 1'b0, req, {15'd0, valid}, 16'd0);   // R8: drops after start
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      check(valid === 1'b0, "R2 valid low while seeding", {15'd0, valid}, 16'd0);
    end
    @(negedge clk);
    gen_en = 1'b0;
    check(valid === 1'b1, "R2 valid after 4 seed cycles", {15'd0, valid}, 16'd1);
    check(pattern === 10'h035, "R3 seeded pattern", {6'd0, pattern}, 16'h035);
    model_seed();
  endtask

  initial begin
    #(PER * 200000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid === 1'b0, "R1 reset valid", {15'd0, valid}, 16'd0);
    check(pattern === 10'h005, "R1 reset pattern", {6'd0, pattern}, 16'h005);
    rst_n = 1'b1;

    // R6: enable while idle has no effect
    gen_en = 1'b1;
    repeat (5) @(negedge clk);
    check(valid === 1'b0, "R6 idle valid", {15'd0, valid}, 16'd0);
    check(pattern === 10'h005, "R6 idle pattern", {6'd0, pattern}, 16'h005);
    gen_en = 1'b0;

    do_start("R2 valid low after start");

    // R4: continuous stepping, checks every cycle
    drive_steps(20, 16'hFFFF, 1'b0);
    // R5: mixed enable pattern with pauses
    drive_steps(32, 16'b1011_0010_1100_0111, 1'b1);
    // R5: long pause
    drive_steps(6, 16'h0000, 1'b0);

    // R8: restart while running gives the same seed
    do_start("R8 valid drops on restart");

    // R4: full period of all segments (lcm 15,7,7 = 105) returns to seed
    drive_steps(105, 16'hFFFF, 1'b0);
    check(pattern === 10'h035, "R4 period returns to seed", {6'd0, pattern}, 16'h035);

    // R8: restart mid-run after odd number of steps
    drive_steps(9, 16'hFFFF, 1'b0);
    do_start("R8 restart after steps");
    drive_steps(12, 16'b0110_1101_1011_0110, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule